// File: doc/BRIEF.md
# Shared-RAM Host Access Port

This block gives a host CPU a byte-wide window onto the shared memory and the control lines of an attached I/O coprocessor. The host first loads a 16-bit memory pointer through two byte registers, one holding the upper byte and one the lower. It then reads or writes shared-RAM bytes through a single data register. When auto-increment is enabled, the pointer advances after each data access, so a block of memory can be streamed without reloading the pointer.

A status/control register holds the coprocessor's run bit, which keeps the coprocessor in reset while it is 0. The same register holds a doorbell interrupt toward the coprocessor and two priority flags raised by the coprocessor toward the host. The coprocessor side has a simple write port into the same single-port RAM, plus strobes that set the two flags. Host bus address bit 0 is not decoded, so every register appears at an even offset and also at the odd offset just above it.

Top module: `shram_host_port`

## Requirements
- R1: After a synchronous active-low reset, the pointer is 0x0000, the control register reads 0x00, and cp_run, cp_irq and host_irq are all low.
- R2: A write at offset 0 loads the pointer's upper byte and a write at offset 2 loads its lower byte. Reads at those offsets return the same bytes. Address bit 0 is ignored, so offsets 1 and 3 alias offsets 0 and 2.
- R3: A write at offset 8 (or 9) stores hwdata into shared RAM at the pointer. A read there returns the byte at the pointer. All read data appears on hrdata in the cycle after the strobe and holds until the next read.
- R4: While control bit 1 (0x02) is set, every data-register access (read or write) adds 1 to the pointer on the edge that completes the access. While it is clear, data accesses leave the pointer unchanged.
- R5: An auto-increment from pointer 0xFFFF gives 0x0000.
- R6: Control bit 2 (0x04) drives cp_run. While the bit is 0, cp_run is low and the coprocessor is held in reset.
- R7: Control bit 3 (0x08) drives the doorbell output cp_irq toward the coprocessor.
- R8: A pulse on cp_int0_set sets control bit 4 (0x10), and a pulse on cp_int1_set sets control bit 5 (0x20). host_irq is high while either flag is set. A host write with a 1 in a flag bit clears that flag, and a 0 leaves it alone. A set and a clear in the same cycle leave the flag set.
- R9: A coprocessor write (cp_we) stores cp_wdata at cp_addr in shared RAM, unless a host data access happens in the same cycle. The host has priority, and cp_grant is low in that cycle to show the write was not performed.
- R10: Offsets 6, 7 and 10 to 15 read as 0x00, and writes to them have no effect. Control bits 0, 6 and 7 always read as 0.
- R11: The RAM has 2^MEM_AW bytes (default 1024) and is indexed by the low MEM_AW bits of the pointer or cp_addr. Addresses that differ only above those bits reach the same byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsel | input | 1 | Host access strobe, one cycle per access |
| hwr | input | 1 | 1 = host write, 0 = host read |
| haddr | input | 4 | Host register byte offset |
| hwdata | input | 8 | Host write data |
| hrdata | output | 8 | Host read data, valid the cycle after a read strobe |
| host_irq | output | 1 | Interrupt to host, high while either flag is set |
| cp_run | output | 1 | Coprocessor run; low holds it in reset |
| cp_irq | output | 1 | Doorbell interrupt toward the coprocessor |
| cp_we | input | 1 | Coprocessor RAM write request |
| cp_addr | input | 16 | Coprocessor RAM byte address |
| cp_wdata | input | 8 | Coprocessor RAM write data |
| cp_grant | output | 1 | Coprocessor write performed this cycle |
| cp_int0_set | input | 1 | Set the low-priority host flag |
| cp_int1_set | input | 1 | Set the high-priority host flag |

## Verification
The assertions check several rules on every cycle. They check the pointer step after each data access with auto-increment on, including the wrap, and the stable pointer with it off. They check that a coprocessor flag set always shows on host_irq in the next cycle, even against a clearing write. They check that the doorbell and run outputs follow control writes, and that cp_grant is low exactly when a host data access collides with a coprocessor write. Some behaviour only the bench scenarios can show: RAM contents read back through the pointer, aliasing through bit 0 and through the upper pointer bits, unmapped offsets reading zero, and the reset state.

// File: rtl/shram_pkg.sv
// Package: shared constants for the shared-RAM host access port.
// Assumes host register offsets are decoded on haddr[3:1] (bit 0 ignored).
package shram_pkg;
    // Word index of each host register (haddr[3:1])
    localparam logic [2:0] IDX_PTR_HI = 3'd0;
    localparam logic [2:0] IDX_PTR_LO = 3'd1;
    localparam logic [2:0] IDX_CTRL   = 3'd2;
    localparam logic [2:0] IDX_DATA   = 3'd4;

    // Control register bit positions
    localparam int BIT_AUTOINC  = 1;
    localparam int BIT_RUN      = 2;
    localparam int BIT_DOORBELL = 3;
    localparam int BIT_FLAG0    = 4;
    localparam int BIT_FLAG1    = 5;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PTR_HI,
        SEL_PTR_LO,
        SEL_CTRL,
        SEL_DATA
    } reg_sel_e;
endpackage

// File: rtl/shram_decode.sv
// Module: host bus address decode.
// Maps a strobed host access onto one register select. Address bit 0 is
// ignored; unmapped offsets give SEL_NONE.
module shram_decode
    import shram_pkg::*;
#(
    parameter int HA_W = 4
) (
    input  logic            hsel,
    input  logic [HA_W-1:0] haddr,
    output reg_sel_e        sel
);
    // Decode the word index into a register select
    always_comb begin
        sel = SEL_NONE;
        if (hsel) begin
            unique case (haddr[3:1])
                IDX_PTR_HI: sel = SEL_PTR_HI;
                IDX_PTR_LO: sel = SEL_PTR_LO;
                IDX_CTRL:   sel = SEL_CTRL;
                IDX_DATA:   sel = SEL_DATA;
                default:    sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/shram_ptr.sv
// Module: shared-RAM memory pointer.
// Loaded a byte at a time; steps by one (wrapping) when told to.
// Assumes load and step are never requested in the same cycle.
module shram_ptr #(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_hi,
    input  logic             ld_lo,
    input  logic [7:0]       wdata,
    input  logic             step,
    output logic [PTR_W-1:0] ptr
);
    localparam int HI_W = PTR_W - 8;

    // Pointer register: byte loads and wrapping increment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (ld_hi) begin
            ptr[PTR_W-1:8] <= wdata[HI_W-1:0];
        end else if (ld_lo) begin
            ptr[7:0] <= wdata;
        end else if (step) begin
            ptr <= ptr + PTR_W'(1);
        end
    end
endmodule

// File: rtl/shram_ctrl.sv
// Module: status/control register.
// Holds auto-increment, run and doorbell bits written by the host, and two
// flags set by the coprocessor and cleared by host write-one. Set wins.
module shram_ctrl
    import shram_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    input  logic       int0_set,
    input  logic       int1_set,
    output logic       autoinc,
    output logic       run,
    output logic       doorbell,
    output logic       host_irq,
    output logic [7:0] rd_byte
);
    logic flag0, flag1;

    // Host-written control bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            autoinc  <= 1'b0;
            run      <= 1'b0;
            doorbell <= 1'b0;
        end else if (wr) begin
            autoinc  <= wdata[BIT_AUTOINC];
            run      <= wdata[BIT_RUN];
            doorbell <= wdata[BIT_DOORBELL];
        end
    end

    // Coprocessor flags: set by strobe, cleared by host write-one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag0 <= 1'b0;
            flag1 <= 1'b0;
        end else begin
            if (int0_set)                       flag0 <= 1'b1;
            else if (wr && wdata[BIT_FLAG0])    flag0 <= 1'b0;
            if (int1_set)                       flag1 <= 1'b1;
            else if (wr && wdata[BIT_FLAG1])    flag1 <= 1'b0;
        end
    end

    // Host interrupt and readback image
    always_comb begin
        host_irq = flag0 | flag1;
        rd_byte  = '0;
        rd_byte[BIT_AUTOINC]  = autoinc;
        rd_byte[BIT_RUN]      = run;
        rd_byte[BIT_DOORBELL] = doorbell;
        rd_byte[BIT_FLAG0]    = flag0;
        rd_byte[BIT_FLAG1]    = flag1;
    end
endmodule

// File: rtl/shram_ram.sv
// Module: single-port byte RAM with registered read.
// Read data updates only when re is set and holds otherwise.
module shram_ram #(
    parameter int MEM_AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MEM_AW-1:0] addr,
    input  logic              we,
    input  logic              re,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << MEM_AW;

    logic [7:0] mem [DEPTH];

    // Storage write port
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    // Registered read port
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= mem[addr];
    end
endmodule

// File: rtl/shram_host_port.sv
// Module: top of the shared-RAM host access port.
// Ties decode, pointer, control and RAM together. Host data accesses take
// the single RAM port before coprocessor writes. Read data is registered.
module shram_host_port
    import shram_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int MEM_AW = 10,
    parameter int HA_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsel,
    input  logic             hwr,
    input  logic [HA_W-1:0]  haddr,
    input  logic [7:0]       hwdata,
    output logic [7:0]       hrdata,
    output logic             host_irq,
    output logic             cp_run,
    output logic             cp_irq,
    input  logic             cp_we,
    input  logic [PTR_W-1:0] cp_addr,
    input  logic [7:0]       cp_wdata,
    output logic             cp_grant,
    input  logic             cp_int0_set,
    input  logic             cp_int1_set
);
    reg_sel_e          sel;
    logic [PTR_W-1:0]  ptr_q;
    logic              autoinc;
    logic              data_acc, ctrl_wr;
    logic [7:0]        ctrl_byte, ram_rdata, ram_wdata, rd_hold_q;
    logic [MEM_AW-1:0] ram_addr;
    logic              ram_we, rd_is_data_q;

    shram_decode #(.HA_W(HA_W)) u_dec (
        .hsel(hsel), .haddr(haddr), .sel(sel)
    );

    // Access classification
    always_comb begin
        data_acc = (sel == SEL_DATA);
        ctrl_wr  = (sel == SEL_CTRL) && hwr;
    end

    shram_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .ld_hi((sel == SEL_PTR_HI) && hwr),
        .ld_lo((sel == SEL_PTR_LO) && hwr),
        .wdata(hwdata),
        .step(data_acc && autoinc),
        .ptr(ptr_q)
    );

    shram_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr(ctrl_wr), .wdata(hwdata),
        .int0_set(cp_int0_set), .int1_set(cp_int1_set),
        .autoinc(autoinc), .run(cp_run), .doorbell(cp_irq),
        .host_irq(host_irq), .rd_byte(ctrl_byte)
    );

    // RAM port arbitration: host data access first
    always_comb begin
        cp_grant = cp_we && !data_acc;
        if (data_acc) begin
            ram_addr  = ptr_q[MEM_AW-1:0];
            ram_we    = hwr;
            ram_wdata = hwdata;
        end else begin
            ram_addr  = cp_addr[MEM_AW-1:0];
            ram_we    = cp_we;
            ram_wdata = cp_wdata;
        end
    end

    shram_ram #(.MEM_AW(MEM_AW)) u_ram (
        .clk(clk), .rst_n(rst_n),
        .addr(ram_addr), .we(ram_we), .re(data_acc && !hwr),
        .wdata(ram_wdata), .rdata(ram_rdata)
    );

    // Capture register read data on a host read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_is_data_q <= 1'b0;
            rd_hold_q    <= '0;
        end else if (hsel && !hwr) begin
            rd_is_data_q <= data_acc;
            unique case (sel)
                SEL_PTR_HI: rd_hold_q <= 8'(ptr_q[PTR_W-1:8]);
                SEL_PTR_LO: rd_hold_q <= ptr_q[7:0];
                SEL_CTRL:   rd_hold_q <= ctrl_byte;
                default:    rd_hold_q <= '0;
            endcase
        end
    end

    // Host read data mux
    always_comb hrdata = rd_is_data_q ? ram_rdata : rd_hold_q;
endmodule

// File: rtl/shram_host_port_chk.sv
// Checker: per-cycle rules of the shared-RAM host access port.
module shram_host_port_chk #(
    parameter int PTR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             data_acc,
    input logic             ctrl_wr,
    input logic [7:0]       hwdata,
    input logic             autoinc,
    input logic [PTR_W-1:0] ptr_q,
    input logic             cp_we,
    input logic             cp_grant,
    input logic             cp_run,
    input logic             cp_irq,
    input logic             host_irq,
    input logic             cp_int0_set,
    input logic             cp_int1_set
);
    // R4 and R5: step with wrap
    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && autoinc) |=> (ptr_q == PTR_W'($past(ptr_q) + PTR_W'(1))));
    assert_ptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && !autoinc) |=> $stable(ptr_q));
    assert_run_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !hwdata[2]) |=> !cp_run);
    assert_doorbell_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && hwdata[3]) |=> cp_irq);
    assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_int0_set || cp_int1_set) |=> host_irq);
    assert_grant_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_we && data_acc) |-> !cp_grant);
    assert_grant_free_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_we && !data_acc) |-> cp_grant);
endmodule

bind shram_host_port shram_host_port_chk #(.PTR_W(PTR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .data_acc(data_acc), .ctrl_wr(ctrl_wr),
    .hwdata(hwdata), .autoinc(autoinc), .ptr_q(ptr_q), .cp_we(cp_we),
    .cp_grant(cp_grant), .cp_run(cp_run), .cp_irq(cp_irq),
    .host_irq(host_irq), .cp_int0_set(cp_int0_set), .cp_int1_set(cp_int1_set)
);

// File: tb/tb_shram_host_port.sv
module tb_shram_host_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsel = 1'b0, hwr = 1'b0;
    logic [3:0]  haddr = '0;
    logic [7:0]  hwdata = '0;
    logic [7:0]  hrdata;
    logic        host_irq, cp_run, cp_irq, cp_grant;
    logic        cp_we = 1'b0, cp_int0_set = 1'b0, cp_int1_set = 1'b0;
    logic [15:0] cp_addr = '0;
    logic [7:0]  cp_wdata = '0;
    int total = 0, bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    shram_host_port dut (
        .clk(clk), .rst_n(rst_n), .hsel(hsel), .hwr(hwr), .haddr(haddr),
        .hwdata(hwdata), .hrdata(hrdata), .host_irq(host_irq), .cp_run(cp_run),
        .cp_irq(cp_irq), .cp_we(cp_we), .cp_addr(cp_addr), .cp_wdata(cp_wdata),
        .cp_grant(cp_grant), .cp_int0_set(cp_int0_set), .cp_int1_set(cp_int1_set)
    );

    // Vector: {req[3:0], is_read, offset[3:0], data[7:0]}
    localparam int NV = 24;
    localparam logic [16:0] VEC [NV] = '{
        {4'd2,  1'b0, 4'h0, 8'h12}, {4'd2,  1'b0, 4'h2, 8'h34},
        {4'd2,  1'b1, 4'h0, 8'h12}, {4'd2,  1'b1, 4'h3, 8'h34},
        {4'd3,  1'b0, 4'h8, 8'hA5}, {4'd3,  1'b1, 4'h8, 8'hA5},
        {4'd4,  1'b1, 4'h2, 8'h34}, {4'd4,  1'b0, 4'h4, 8'h02},
        {4'd3,  1'b0, 4'h9, 8'h5A}, {4'd4,  1'b1, 4'h2, 8'h35},
        {4'd4,  1'b0, 4'h8, 8'hC3}, {4'd4,  1'b0, 4'h2, 8'h34},
        {4'd3,  1'b1, 4'h8, 8'h5A}, {4'd3,  1'b1, 4'h8, 8'hC3},
        {4'd4,  1'b1, 4'h2, 8'h36}, {4'd4,  1'b1, 4'h4, 8'h02},
        {4'd10, 1'b0, 4'h6, 8'hFF}, {4'd10, 1'b1, 4'h6, 8'h00},
        {4'd10, 1'b1, 4'h2, 8'h36}, {4'd10, 1'b0, 4'h4, 8'hFF},
        {4'd10, 1'b1, 4'h4, 8'h0E}, {4'd10, 1'b0, 4'h4, 8'h00},
        {4'd10, 1'b1, 4'h4, 8'h00}, {4'd10, 1'b1, 4'hC, 8'h00}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); hsel = 1'b1; hwr = 1'b1; haddr = a; hwdata = d;
        @(negedge clk); hsel = 1'b0; hwr = 1'b0;
    endtask

    task automatic hread(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); hsel = 1'b1; hwr = 1'b0; haddr = a;
        @(negedge clk); hsel = 1'b0; d = hrdata;
    endtask

    task automatic set_ptr(input logic [15:0] p);
        hwrite(4'h0, p[15:8]); hwrite(4'h2, p[7:0]);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        check("R1 run", 16'(cp_run), 16'd0);
        check("R1 doorbell", 16'(cp_irq), 16'd0);
        check("R1 host_irq", 16'(host_irq), 16'd0);
        hread(4'h0, d); check("R1 ptr hi", 16'(d), 16'h00);
        hread(4'h2, d); check("R1 ptr lo", 16'(d), 16'h00);
        hread(4'h4, d); check("R1 ctrl", 16'(d), 16'h00);

        // Vector table: R2 R3 R4 R10
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][12]) begin
                hread(VEC[i][11:8], d);
                check($sformatf("R%0d vec%0d", VEC[i][16:13], i), 16'(d), 16'(VEC[i][7:0]));
            end else begin
                hwrite(VEC[i][11:8], VEC[i][7:0]);
            end
        end

        // R5 wrap
        set_ptr(16'hFFFF); hwrite(4'h4, 8'h02); hwrite(4'h8, 8'h77);
        hread(4'h0, d); check("R5 hi after wrap", 16'(d), 16'h00);
        hread(4'h2, d); check("R5 lo after wrap", 16'(d), 16'h00);
        hwrite(4'h4, 8'h00); set_ptr(16'hFFFF);
        hread(4'h8, d); check("R5 data at FFFF", 16'(d), 16'h77);

        // R6 run, R7 doorbell
        hwrite(4'h4, 8'h04);
        check("R6 run set", 16'(cp_run), 16'd1);
        check("R7 doorbell off", 16'(cp_irq), 16'd0);
        hwrite(4'h4, 8'h08);
        check("R6 run cleared", 16'(cp_run), 16'd0);
        check("R7 doorbell on", 16'(cp_irq), 16'd1);
        hwrite(4'h4, 8'h00);

        // R8 flags
        @(negedge clk); cp_int0_set = 1'b1;
        @(negedge clk); cp_int0_set = 1'b0;
        check("R8 irq from flag0", 16'(host_irq), 16'd1);
        hread(4'h4, d); check("R8 flag0 read", 16'(d), 16'h10);
        hwrite(4'h4, 8'h20);
        hread(4'h4, d); check("R8 zero keeps flag0", 16'(d), 16'h10);
        hwrite(4'h4, 8'h10);
        hread(4'h4, d); check("R8 flag0 cleared", 16'(d), 16'h00);
        check("R8 irq low", 16'(host_irq), 16'd0);
        @(negedge clk); cp_int1_set = 1'b1;
        @(negedge clk); cp_int1_set = 1'b0;
        hread(4'h4, d); check("R8 flag1 read", 16'(d), 16'h20);
        check("R8 irq from flag1", 16'(host_irq), 16'd1);
        hwrite(4'h4, 8'h20);
        @(negedge clk); cp_int0_set = 1'b1; hsel = 1'b1; hwr = 1'b1;
        haddr = 4'h4; hwdata = 8'h10;
        @(negedge clk); cp_int0_set = 1'b0; hsel = 1'b0; hwr = 1'b0;
        hread(4'h4, d); check("R8 set wins over clear", 16'(d), 16'h10);
        hwrite(4'h4, 8'h30);

        // R9 coprocessor writes
        @(negedge clk); cp_we = 1'b1; cp_addr = 16'h0100; cp_wdata = 8'h3C;
        @(negedge clk); cp_addr = 16'h0101; cp_wdata = 8'h44;
        @(negedge clk); cp_we = 1'b0;
        set_ptr(16'h0100);
        hread(4'h8, d); check("R9 cp write", 16'(d), 16'h3C);
        set_ptr(16'h0200);
        @(negedge clk); cp_we = 1'b1; cp_addr = 16'h0101; cp_wdata = 8'h99;
        hsel = 1'b1; hwr = 1'b1; haddr = 4'h8; hwdata = 8'h11;
        #1 check("R9 grant low on clash", 16'(cp_grant), 16'd0);
        @(negedge clk); cp_we = 1'b0; hsel = 1'b0; hwr = 1'b0;
        set_ptr(16'h0101);
        hread(4'h8, d); check("R9 blocked write lost", 16'(d), 16'h44);
        set_ptr(16'h0200);
        hread(4'h8, d); check("R9 host write won", 16'(d), 16'h11);

        // R11 aliasing above MEM_AW bits
        set_ptr(16'h0005); hwrite(4'h8, 8'hE7);
        set_ptr(16'h0405);
        hread(4'h8, d); check("R11 alias", 16'(d), 16'hE7);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule